// File: doc/BRIEF.md
# Synchronous DRAM Write Burst Data Path

This block is the device-side write path of a four-bank synchronous DRAM. It decodes commands from the active-low chip select, row strobe, column strobe and write enable inputs. An ACTIVE command opens a row in a bank. A MODE REGISTER SET command programs the burst length and the write mode. A WRITE command stores data from the DQ bus into a small internal storage array. The first beat is taken on the same edge as the WRITE command. The following beats, if any, are taken on the next consecutive edges.

In burst write mode a WRITE stores 1, 2, 4 or 8 beats, as set by the programmed length. The columns run upward from the start column and wrap inside the aligned block whose size is the burst length. In single write mode a WRITE stores one beat only, whatever length is programmed. Each bank has a delay counter. A WRITE that arrives fewer than `TRCD` cycles after the ACTIVE to its bank, or that targets a bank never opened, is refused and flagged. A read port with no clock lets the contents of the storage array be inspected directly.

Top module: `sdram_wr_path`

## Requirements
- R1: After reset `busy` and `wr_err` are low, every storage word reads zero, and the mode is burst write with a length of 1.
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n}. ACTIVE = 0,0,1,1. WRITE = 0,1,0,0. MODE REGISTER SET = 0,0,0,0. When cs_n is high, or any other pattern is presented, nothing is done.
- R3: ACTIVE latches `addr[ROW_W-1:0]` as the open row of bank `ba` and restarts that bank's delay count. A WRITE to bank b is accepted only if at least `TRCD` clock edges have passed since the latest ACTIVE to b; an ACTIVE at edge k allows a WRITE at edge k+TRCD. Any other WRITE stores nothing and sets `wr_err` high for the one cycle after its edge. A burst already running goes on as if no WRITE had been presented.
- R4: An accepted WRITE stores the `dq` value present at its own edge. The target is bank `ba`, that bank's open row, and column `addr[COL_W-1:0]`.
- R5: MODE REGISTER SET loads the burst length code from `addr[2:0]` (0→1, 1→2, 2→4, 3→8 beats) and the write mode from `addr[9]` (0 = burst, 1 = single). If `addr[2]` = 1 or `addr[8]` = 1, the mode register is left unchanged.
- R6: In burst mode an accepted WRITE with length L stores L beats on L consecutive edges, each beat taken from `dq` at its own edge. `busy` is high after every edge that leaves beats still to be stored.
- R7: Beat i of a burst with length L and start column c goes to column (c − c mod L) + ((c + i) mod L).
- R8: In single mode an accepted WRITE stores exactly one beat and leaves `busy` low.
- R9: An accepted WRITE during a burst ends the old burst. Its own first beat is stored at that edge, and its burst continues from there.
- R10: A MODE REGISTER SET presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Row, column or mode value, depending on the command |
| dq | input | DQ_W | Write data |
| busy | output | 1 | Burst beats still pending |
| wr_err | output | 1 | A WRITE was refused on the previous edge |
| rd_bank | input | BA_W | Inspection port bank |
| rd_row | input | ROW_W | Inspection port row |
| rd_col | input | COL_W | Inspection port column |
| rd_data | output | DQ_W | Storage word at the inspection address, with no clock delay |

## Verification
The data bus carries a new value on every cycle, so each stored word shows the edge at which it was taken. This separates zero-latency capture from capture one edge late, and beats that were dropped from beats that were repeated. Bursts of every length start at columns in the middle of their aligned block, which exposes linear addressing where wrapping addressing is needed. Single mode is run with a length of eight programmed, so a stray extra beat stands out. Further sequences cover a WRITE that interrupts a burst, a refused WRITE during a burst, a mode load while busy, reserved mode values, deselected cycles, and writes that arrive one edge too early or go to an unopened bank; each one tells ignoring the stimulus apart from acting on it.

// File: rtl/sdram_wr_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the write data path.
// Assumes a burst of at most eight beats.
package sdram_wr_pkg;

    // Decoded command kinds; everything outside the set maps to CMD_NOP
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_MRS = 2'd3
    } sdr_cmd_e;

    // Width of the beat counters (up to eight beats)
    localparam int unsigned BEAT_W = 3;

    // Burst length minus one for a length code, or zero in single mode
    function automatic logic [BEAT_W-1:0] beats_m1(input logic [1:0] code,
                                                   input logic       single);
        logic [BEAT_W-1:0] r;
        if (single) begin
            r = '0;
        end else begin
            case (code)
                2'd0:    r = 3'd0;
                2'd1:    r = 3'd1;
                2'd2:    r = 3'd3;
                default: r = 3'd7;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: maps the four active-low control strobes to a command
// kind. Purely combinational. Assumes the strobes are stable around the edge.
module sdram_cmd_decode
    import sdram_wr_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdr_cmd_e cmd
);

    // Truth table for the supported commands
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WR;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
`timescale 1ns/1ps
// Per-bank row tracker: keeps the open flag, the latched row and a
// saturating count of edges since the latest ACTIVE for each bank. Reports
// whether the queried bank may take a WRITE, and gives its row.
// Assumes BANKS is a power of two and TRCD >= 1.
module sdram_bank_track #(
    parameter  int BANKS = 4,
    parameter  int ROW_W = 2,
    parameter  int TRCD  = 3,
    localparam int BA_W  = $clog2(BANKS),
    localparam int CNT_W = $clog2(TRCD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic [BA_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic [BA_W-1:0]  q_bank,
    output logic             q_ready,
    output logic [ROW_W-1:0] q_row
);

    logic             ready_vec [BANKS];
    logic [ROW_W-1:0] row_vec   [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        logic [CNT_W-1:0] cnt_r;

        // Latch the row on ACTIVE and count edges up to TRCD
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_r <= 1'b0;
                row_r  <= '0;
                cnt_r  <= '0;
            end else if (act && act_bank == BA_W'(g)) begin
                open_r <= 1'b1;
                row_r  <= act_row;
                cnt_r  <= CNT_W'(1);
            end else if (cnt_r != CNT_W'(TRCD)) begin
                cnt_r  <= cnt_r + CNT_W'(1);
            end
        end

        assign ready_vec[g] = open_r && (cnt_r == CNT_W'(TRCD));
        assign row_vec[g]   = row_r;
    end

    // Select the bank addressed by the current command
    always_comb begin
        q_ready = ready_vec[q_bank];
        q_row   = row_vec[q_bank];
    end

endmodule

// File: rtl/sdram_mode_reg.sv
`timescale 1ns/1ps
// Mode register: holds the burst length code and the single-write flag.
// A load that carries a reserved value is dropped whole. The caller gates
// load while a burst is in progress.
module sdram_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] len_field,
    input  logic       wm_hi,
    input  logic       wm_lo,
    output logic [1:0] len_code,
    output logic       single
);

    logic valid_val;

    // A value is usable when the length code and write mode are defined
    always_comb valid_val = !len_field[2] && !wm_lo;

    // Load the fields on an accepted, valid mode set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_code <= 2'd0;
            single   <= 1'b0;
        end else if (load && valid_val) begin
            len_code <= len_field[1:0];
            single   <= wm_hi;
        end
    end

endmodule

// File: rtl/sdram_burst_gen.sv
`timescale 1ns/1ps
// Burst generator: on an accepted WRITE, forwards the first beat's target
// straight through. It then steps a wrapping column across the remaining
// beats. A new start replaces any burst in progress. Assumes COL_W >= 3.
module sdram_burst_gen
    import sdram_wr_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 2,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BA_W-1:0]  start_bank,
    input  logic [ROW_W-1:0] start_row,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_code,
    input  logic             single,
    output logic             busy,
    output logic             st_en,
    output logic [BA_W-1:0]  st_bank,
    output logic [ROW_W-1:0] st_row,
    output logic [COL_W-1:0] st_col
);

    logic [BEAT_W-1:0] rem_r;
    logic [BEAT_W-1:0] idx_r;
    logic [BEAT_W-1:0] mask_r;
    logic [COL_W-1:0]  base_r;
    logic [BA_W-1:0]   bank_r;
    logic [ROW_W-1:0]  row_r;
    logic [BEAT_W-1:0] new_m1;
    logic [COL_W-1:0]  mask_c;
    logic [COL_W-1:0]  wrap_col;

    // Length of the burst being started, minus one
    always_comb new_m1 = beats_m1(len_code, single);

    // Column of the current follow-on beat, wrapped within its aligned block
    always_comb begin
        mask_c   = COL_W'(mask_r);
        wrap_col = (base_r & ~mask_c) | ((base_r + COL_W'(idx_r)) & mask_c);
    end

    // Storage strobes: the start beat has priority over a running burst
    always_comb begin
        if (start) begin
            st_en   = 1'b1;
            st_bank = start_bank;
            st_row  = start_row;
            st_col  = start_col;
        end else begin
            st_en   = (rem_r != '0);
            st_bank = bank_r;
            st_row  = row_r;
            st_col  = wrap_col;
        end
    end

    // Burst state: load on start, otherwise count remaining beats down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r  <= '0;
            idx_r  <= '0;
            mask_r <= '0;
            base_r <= '0;
            bank_r <= '0;
            row_r  <= '0;
        end else if (start) begin
            rem_r  <= new_m1;
            idx_r  <= BEAT_W'(1);
            mask_r <= new_m1;
            base_r <= start_col;
            bank_r <= start_bank;
            row_r  <= start_row;
        end else if (rem_r != '0) begin
            rem_r  <= rem_r - BEAT_W'(1);
            idx_r  <= idx_r + BEAT_W'(1);
        end
    end

    assign busy = (rem_r != '0);

endmodule

// File: rtl/sdram_store_array.sv
`timescale 1ns/1ps
// Storage array: one word per bank/row/column. One synchronous write port
// and one read port with no clock. Cleared by reset so its contents are
// known. The depth stays small at the default parameters.
module sdram_store_array #(
    parameter  int BANKS = 4,
    parameter  int ROW_W = 2,
    parameter  int COL_W = 4,
    parameter  int DQ_W  = 8,
    localparam int BA_W  = $clog2(BANKS),
    localparam int IDX_W = BA_W + ROW_W + COL_W,
    localparam int DEPTH = BANKS << (ROW_W + COL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BA_W-1:0]  w_bank,
    input  logic [ROW_W-1:0] w_row,
    input  logic [COL_W-1:0] w_col,
    input  logic [DQ_W-1:0]  w_data,
    input  logic [BA_W-1:0]  r_bank,
    input  logic [ROW_W-1:0] r_row,
    input  logic [COL_W-1:0] r_col,
    output logic [DQ_W-1:0]  r_data
);

    logic [DQ_W-1:0]  mem [DEPTH];
    logic [IDX_W-1:0] w_idx;
    logic [IDX_W-1:0] r_idx;

    // Flatten bank, row and column into one word index
    always_comb begin
        w_idx = {w_bank, w_row, w_col};
        r_idx = {r_bank, r_row, r_col};
    end

    // Clear on reset, otherwise store one beat per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[w_idx] <= w_data;
        end
    end

    // Inspection read with no clock
    assign r_data = mem[r_idx];

endmodule

// File: rtl/sdram_wr_path.sv
`timescale 1ns/1ps
// Write data path top: decodes commands, checks each WRITE against the
// per-bank row delay, holds the mode register, and drives the burst
// generator that fills the storage array. Write data has zero latency.
// Assumes ADDR_W >= 10, BANKS a power of two, COL_W >= 3.
module sdram_wr_path
    import sdram_wr_pkg::*;
#(
    parameter  int BANKS  = 4,
    parameter  int ROW_W  = 2,
    parameter  int COL_W  = 4,
    parameter  int DQ_W   = 8,
    parameter  int ADDR_W = 10,
    parameter  int TRCD   = 3,
    localparam int BA_W   = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq,
    output logic              busy,
    output logic              wr_err,
    input  logic [BA_W-1:0]   rd_bank,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DQ_W-1:0]   rd_data
);

    localparam int WM_HI = 9;
    localparam int WM_LO = 8;

    sdr_cmd_e         cmd;
    logic             is_act;
    logic             is_wr;
    logic             is_mrs;
    logic             bank_ready;
    logic [ROW_W-1:0] bank_row;
    logic             wr_ok;
    logic [1:0]       mode_bl;
    logic             mode_single;
    logic             st_en;
    logic [BA_W-1:0]  st_bank;
    logic [ROW_W-1:0] st_row;
    logic [COL_W-1:0] st_col;
    logic             addr_unused;

    // Some address bits carry no meaning for this path
    assign addr_unused = ^addr;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // One-hot views of the decoded command
    always_comb begin
        is_act = (cmd == CMD_ACT);
        is_wr  = (cmd == CMD_WR);
        is_mrs = (cmd == CMD_MRS);
    end

    sdram_bank_track #(
        .BANKS (BANKS),
        .ROW_W (ROW_W),
        .TRCD  (TRCD)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (is_act),
        .act_bank (ba),
        .act_row  (addr[ROW_W-1:0]),
        .q_bank   (ba),
        .q_ready  (bank_ready),
        .q_row    (bank_row)
    );

    // A WRITE is taken only by an open bank whose delay has elapsed
    always_comb wr_ok = is_wr && bank_ready;

    // Flag a refused WRITE for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= is_wr && !bank_ready;
    end

    sdram_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (is_mrs && !busy),
        .len_field (addr[2:0]),
        .wm_hi     (addr[WM_HI]),
        .wm_lo     (addr[WM_LO]),
        .len_code  (mode_bl),
        .single    (mode_single)
    );

    sdram_burst_gen #(
        .BA_W  (BA_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wr_ok),
        .start_bank (ba),
        .start_row  (bank_row),
        .start_col  (addr[COL_W-1:0]),
        .len_code   (mode_bl),
        .single     (mode_single),
        .busy       (busy),
        .st_en      (st_en),
        .st_bank    (st_bank),
        .st_row     (st_row),
        .st_col     (st_col)
    );

    sdram_store_array #(
        .BANKS (BANKS),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DQ_W  (DQ_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_en),
        .w_bank (st_bank),
        .w_row  (st_row),
        .w_col  (st_col),
        .w_data (dq),
        .r_bank (rd_bank),
        .r_row  (rd_row),
        .r_col  (rd_col),
        .r_data (rd_data)
    );

endmodule

// File: rtl/sdram_wr_path_chk.sv
`timescale 1ns/1ps
// Property checker for the write data path, attached by bind.
module sdram_wr_path_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              wr_err,
    input logic              wr_ok,
    input logic [1:0]        mode_bl,
    input logic              mode_single
);

    logic wr_cmd;
    logic mrs_cmd;

    // Recognise commands from the raw strobes
    always_comb begin
        wr_cmd  = !cs_n && ras_n && !cas_n && !we_n;
        mrs_cmd = !cs_n && !ras_n && !cas_n && !we_n;
    end

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_cmd));

    // R6
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_ok));

    // R6
    long_burst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !mode_single && mode_bl != 2'd0) |=> busy);

    // R8
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && mode_single) |=> !busy);

    // R10
    mrs_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mrs_cmd) |=> ($stable(mode_bl) && $stable(mode_single)));

    // R5
    mrs_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_cmd && (addr[2] || addr[8])) |=> ($stable(mode_bl) && $stable(mode_single)));

endmodule

bind sdram_wr_path sdram_wr_path_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .addr        (addr),
    .busy        (busy),
    .wr_err      (wr_err),
    .wr_ok       (wr_ok),
    .mode_bl     (mode_bl),
    .mode_single (mode_single)
);

// File: tb/sdram_wr_path_test.sv
`timescale 1ns/1ps
module sdram_wr_path_test;

    localparam int BANKS = 4;
    localparam int ROW_W = 2;
    localparam int COL_W = 4;
    localparam int DQ_W  = 8;
    localparam int ADDR_W = 10;
    localparam int TRCD  = 3;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;
    localparam int DEPTH = BANKS * ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]        ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0]   dq = '0;
    logic              busy, wr_err;
    logic [1:0]        rd_bank = '0;
    logic [ROW_W-1:0]  rd_row = '0;
    logic [COL_W-1:0]  rd_col = '0;
    logic [DQ_W-1:0]   rd_data;

    int checks = 0;
    int failures = 0;
    logic [DQ_W-1:0] dval = 8'h11;

    // reference model state
    int mem_m [DEPTH];
    bit open_m [BANKS];
    int row_m [BANKS];
    int el_m [BANKS];
    int bl_m;
    bit single_m;
    int q_col [$];
    int qb, qr;
    bit err_exp;
    bit run_chk = 1'b0;

    sdram_wr_path uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dq(dq), .busy(busy), .wr_err(wr_err),
        .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic int midx(int b, int r, int c);
        return (b * ROWS + r) * COLS + c;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        bit a, w, m, busy_pre, ok;
        int c, len;
        if (!rst_n) begin
            foreach (mem_m[i]) mem_m[i] = 0;
            foreach (open_m[i]) begin open_m[i] = 0; row_m[i] = 0; el_m[i] = 0; end
            bl_m = 1; single_m = 0; q_col.delete(); err_exp = 0;
        end else begin
            a = !cs_n && !ras_n && cas_n && we_n;
            w = !cs_n && ras_n && !cas_n && !we_n;
            m = !cs_n && !ras_n && !cas_n && !we_n;
            busy_pre = q_col.size() != 0;
            ok = w && open_m[ba] && (el_m[ba] >= TRCD - 1);
            err_exp = w && !ok;
            c = int'(addr[COL_W-1:0]);
            if (ok) begin
                q_col.delete();
                len = single_m ? 1 : bl_m;
                mem_m[midx(ba, row_m[ba], c)] = int'(dq);
                qb = ba; qr = row_m[ba];
                for (int i = 1; i < len; i++) q_col.push_back((c / len) * len + (c + i) % len);
            end else if (q_col.size() != 0) begin
                mem_m[midx(qb, qr, q_col[0])] = int'(dq);
                void'(q_col.pop_front());
            end
            if (m && !busy_pre && !addr[2] && !addr[8]) begin
                bl_m = 1 << addr[1:0];
                single_m = addr[9];
            end
            foreach (el_m[i]) el_m[i]++;
            if (a) begin open_m[ba] = 1; row_m[ba] = int'(addr[ROW_W-1:0]); el_m[ba] = 0; end
        end
    end

    // Per-cycle comparison of the flags, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            check("R6", "busy", int'(busy), int'(q_col.size() != 0));
            check("R3", "wr_err", int'(wr_err), int'(err_exp));
        end
    end

    task automatic drive(input bit c, input bit r, input bit k, input bit e, input int b, input int ad);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = k; we_n = e;
        ba = 2'(b); addr = ADDR_W'(ad); dq = dval; dval = dval + 8'd7;
    endtask
    task automatic nop();           drive(1, 1, 1, 1, 0, 0);         endtask
    task automatic act(int b, int r); drive(0, 0, 1, 1, b, r);       endtask
    task automatic wr(int b, int c);  drive(0, 1, 0, 0, b, c);       endtask
    task automatic mrs(int v);        drive(0, 0, 0, 0, 0, v);       endtask
    task automatic nops(int n); for (int i = 0; i < n; i++) nop(); endtask

    // Compare every storage word against the model
    task automatic sweep(input string req);
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            {rd_bank, rd_row, rd_col} = 8'(i);
            #0.01;
            check(req, $sformatf("mem[%0d]", i), int'(rd_data), mem_m[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "busy at reset", int'(busy), 0);
        check("R1", "wr_err at reset", int'(wr_err), 0);
        sweep("R1");
        @(negedge clk);
        rst_n = 1'b1;
        run_chk = 1'b1;

        // R3: unopened bank, early write, then on-time write at length 1 (R1 default)
        wr(1, 3);
        act(0, 1); nop(); wr(0, 2); wr(0, 2); nops(2);
        sweep("R4");

        // R6 R7: length 8 from the middle of the block
        mrs(3); wr(0, 5); nops(9);
        // length 4 wrapping at the top of the columns
        mrs(2); act(2, 3); nops(3); wr(2, 13); nops(5);
        mrs(1); wr(2, 6); nops(3);
        sweep("R7");

        // R8: single mode with length 8 programmed
        mrs('h203); wr(0, 9); nops(3);
        sweep("R8");

        // R9: interrupt a burst
        mrs(3); wr(0, 0); nop(); nop(); wr(2, 4); nops(9);
        sweep("R9");

        // R10: mode set while busy is dropped
        wr(0, 8); nop(); mrs(0); nops(8); wr(2, 0); nops(9);
        sweep("R10");

        // R5: reserved values leave length 8 in place
        mrs(4); mrs('h100); wr(1, 0); act(1, 2); nops(3); wr(1, 3); nops(9);
        sweep("R5");

        // R3: refused write during a burst, then row relatch
        wr(0, 0); nop(); wr(3, 5); nops(8);
        act(0, 2); wr(0, 1); nops(2); wr(0, 1); nops(9);
        sweep("R3");

        // R2: deselect and unsupported patterns do nothing
        drive(1, 1, 0, 0, 0, 7); drive(0, 1, 0, 1, 0, 7); drive(0, 0, 1, 0, 0, 7);
        drive(1, 0, 0, 0, 0, 'h203); wr(2, 9); nops(9);
        sweep("R2");

        run_chk = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule